// File: doc/BRIEF.md
# I2C Control Register Sequencer

This block holds the CPU-visible control register and the protocol state code of an I2C controller that can act as master or as slave. The CPU writes control bits. The block turns them into START and STOP requests for a bit-level bus engine and holds the clock low while software services the interrupt flag. It also decides whether the engine answers a received byte with ACK or NACK. The engine reports each protocol step as an 8-bit state code. Every code except the idle code F8h sets the interrupt flag.

The flag is the handshake between software and the bus. While the flag is set, SCL is stretched and no queued request moves forward. Writing 0 to the flag releases the clock and lets the sequence continue. When START and STOP are requested together, the block sends STOP first and START after it.

Top module: `i2c_ctl_seq`

## Requirements
- R1: After reset the control register reads 00h and the state code reads F8h. The irq, scl_hold, start_req, stop_req, ack_drive and last_byte outputs are all 0.
- R2: Control bit positions are: bit 7 interrupt enable, bit 6 bus enable, bit 5 start request, bit 4 stop request, bit 3 interrupt flag, bit 2 acknowledge enable. Bits 1:0 read 0. A write loads bits 7, 6, 5 and 2 directly.
- R3: irq is 1 exactly when the interrupt flag and interrupt enable are both 1.
- R4: With the bus enabled, an engine event loads ev_code into the state code. Any code other than F8h also sets the flag. If an event and a CPU clear of the flag land in the same cycle, the set wins.
- R5: With the bus disabled, engine events are ignored, no START or STOP is requested and scl_hold stays 0.
- R6: scl_hold is 1 while the bus is enabled and the flag is set. Writing 0 to bit 3 clears the flag. Writing 1 to bit 3 does not change it.
- R7: In master mode a pending stop raises stop_req and holds it until eng_done. On the cycle after eng_done, the stop bit is 0 and the state code is F8h.
- R8: In slave mode a pending stop never raises stop_req. One cycle after it is seen, the stop bit clears and the state code becomes F8h.
- R9: With start and stop both pending, start_req is raised only after the stop has completed. start_req is held until eng_done, and then the start bit clears.
- R10: Writing 0 to bit 4 leaves a pending stop request unchanged.
- R11: ack_drive is 1 only when the bus is enabled, acknowledge enable is 1, and rx_kind is one of: 1 (own address or either 10-bit address byte), 3 (data byte), or 2 (general call) with gc_enable set. rx_kind 0 and a general call without gc_enable give 0.
- R12: last_byte is 1 when the bus is enabled, slave_tx is 1 and acknowledge enable is 0.
- R13: While the flag is set, a pending start or stop issues no request and is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Control register write strobe |
| cpu_wdata | input | 6 | Write data for control bits 7:2 |
| ctl_rdata | output | 8 | Control register readback |
| state_code | output | 8 | Current protocol state code |
| irq | output | 1 | Interrupt request |
| is_master | input | 1 | 1 when the controller acts as master |
| gc_enable | input | 1 | General-call acceptance enable |
| ev_valid | input | 1 | Engine reports a new state code |
| ev_code | input | 8 | State code reported by the engine |
| rx_kind | input | 2 | Class of the byte just received |
| slave_tx | input | 1 | Controller is in slave-transmit mode |
| ack_drive | output | 1 | 1 = ACK, 0 = NACK in the acknowledge slot |
| last_byte | output | 1 | Current transmit byte is the final one |
| start_req | output | 1 | Request the engine to send START |
| stop_req | output | 1 | Request the engine to send STOP |
| eng_done | input | 1 | Engine finished the requested condition |
| scl_hold | output | 1 | Hold SCL low (clock stretch) |

## Verification
The block has no parameters, so the bench builds it exactly as it is. A behavioural stub acknowledges each START or STOP request three cycles after the request is raised. This exposes the hold-until-done behaviour and the gap between STOP and START in a combined request. A reference model is compared on every clock. Directed checks cover the STOP-before-START ordering, the stop bit ignoring a write of 0, requests waiting while the flag is set, and every rx_kind with the gc_enable and acknowledge-enable settings.

// File: rtl/i2c_ctl_seq.sv
module i2c_ctl_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr,
  input  logic [7:2] cpu_wdata,
  output logic [7:0] ctl_rdata,
  output logic [7:0] state_code,
  output logic       irq,
  input  logic       is_master,
  input  logic       gc_enable,
  input  logic       ev_valid,
  input  logic [7:0] ev_code,
  input  logic [1:0] rx_kind,
  input  logic       slave_tx,
  output logic       ack_drive,
  output logic       last_byte,
  output logic       start_req,
  output logic       stop_req,
  input  logic       eng_done,
  output logic       scl_hold
);
  localparam logic [7:0] IDLE_CODE = 8'hF8;
  localparam logic [1:0] PH_IDLE = 2'd0, PH_STOP = 2'd1, PH_START = 2'd2;
  localparam logic [1:0] RX_ADDR = 2'd1, RX_GCALL = 2'd2, RX_DATA = 2'd3;

  logic       ien, enab, sta, stp, iflg, aak;
  logic [1:0] ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {ien, enab, sta, stp, iflg, aak} <= '0;
      state_code <= IDLE_CODE;
      ph <= PH_IDLE;
    end else begin
      if (cpu_wr) begin
        ien  <= cpu_wdata[7];
        enab <= cpu_wdata[6];
        sta  <= cpu_wdata[5];
        aak  <= cpu_wdata[2];
        if (cpu_wdata[4]) stp <= 1'b1;
        if (!cpu_wdata[3]) iflg <= 1'b0;
      end
      if (enab && ev_valid) begin
        state_code <= ev_code;
        if (ev_code != IDLE_CODE) iflg <= 1'b1;
      end
      if (!enab) ph <= PH_IDLE;
      else begin
        case (ph)
          PH_IDLE:
            if (!iflg) begin
              if (stp) begin
                if (is_master) ph <= PH_STOP;
                else begin
                  stp <= 1'b0;
                  state_code <= IDLE_CODE;
                end
              end else if (sta) ph <= PH_START;
            end
          PH_STOP:
            if (eng_done) begin
              stp <= 1'b0;
              state_code <= IDLE_CODE;
              ph <= PH_IDLE;
            end
          PH_START:
            if (eng_done) begin
              sta <= 1'b0;
              ph <= PH_IDLE;
            end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  assign ctl_rdata = {ien, enab, sta, stp, iflg, aak, 2'b00};
  assign irq       = ien & iflg;
  assign scl_hold  = enab & iflg;
  assign stop_req  = (ph == PH_STOP);
  assign start_req = (ph == PH_START);
  assign ack_drive = enab & aak & ((rx_kind == RX_ADDR) | (rx_kind == RX_DATA) |
                                   ((rx_kind == RX_GCALL) & gc_enable));
  assign last_byte = enab & slave_tx & ~aak;

  assert_flag_on_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enab && ev_valid && ev_code != IDLE_CODE) |=> (ctl_rdata[3] && scl_hold));
  assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enab && !cpu_wr) |=> (!start_req && !stop_req && !scl_hold));
  assert_stop_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !eng_done && enab) |=> stop_req);
  assert_slave_no_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> $past(is_master));
  assert_stop_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> (!ctl_rdata[4] && !stop_req));
  assert_stp_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !eng_done && enab) |=> ctl_rdata[4]);
  assert_wait_on_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg && !start_req && !stop_req) |=> (!$rose(start_req) && !$rose(stop_req)));
endmodule

// File: tb/test_i2c_ctl_seq.sv
module test_i2c_ctl_seq;
  logic clk = 0, rst_n = 0;
  logic cpu_wr = 0, is_master = 0, gc_enable = 0, ev_valid = 0, slave_tx = 0, eng_done = 0;
  logic [7:2] cpu_wdata = '0;
  logic [7:0] ev_code = '0;
  logic [1:0] rx_kind = '0;
  logic [7:0] ctl_rdata, state_code;
  logic irq, ack_drive, last_byte, start_req, stop_req, scl_hold;

  int n_chk = 0, n_fail = 0, cyc = 0, reqcnt = 0;
  int first_stop = -1, first_start = -1;
  bit m_ien, m_enab, m_sta, m_stp, m_iflg, m_aak;
  int m_state, m_ph;

  always #5 clk = ~clk;

  i2c_ctl_seq i_i2c_ctl_seq (.clk, .rst_n, .cpu_wr, .cpu_wdata, .ctl_rdata, .state_code, .irq,
    .is_master, .gc_enable, .ev_valid, .ev_code, .rx_kind, .slave_tx, .ack_drive, .last_byte,
    .start_req, .stop_req, .eng_done, .scl_hold);

  // reference model: spec-level next state from the inputs seen at the edge
  always @(posedge clk) begin
    bit n_sta, n_stp, n_iflg;
    int n_state, n_ph;
    if (!rst_n) begin
      {m_ien, m_enab, m_sta, m_stp, m_iflg, m_aak} = '0;
      m_state = 248; m_ph = 0;
    end else begin
      n_sta = m_sta; n_stp = m_stp; n_iflg = m_iflg; n_state = m_state; n_ph = m_ph;
      if (cpu_wr) begin
        n_sta = cpu_wdata[5];
        if (cpu_wdata[4]) n_stp = 1;
        if (!cpu_wdata[3]) n_iflg = 0;
      end
      if (m_enab && ev_valid) begin
        n_state = ev_code;
        if (ev_code != 248) n_iflg = 1;
      end
      if (!m_enab) n_ph = 0;
      else if (m_ph == 0 && !m_iflg && m_stp && is_master) n_ph = 1;
      else if (m_ph == 0 && !m_iflg && m_stp) begin n_stp = 0; n_state = 248; end
      else if (m_ph == 0 && !m_iflg && m_sta) n_ph = 2;
      else if (m_ph == 1 && eng_done) begin n_stp = 0; n_state = 248; n_ph = 0; end
      else if (m_ph == 2 && eng_done) begin n_sta = 0; n_ph = 0; end
      if (cpu_wr) begin m_ien = cpu_wdata[7]; m_enab = cpu_wdata[6]; m_aak = cpu_wdata[2]; end
      m_sta = n_sta; m_stp = n_stp; m_iflg = n_iflg; m_state = n_state; m_ph = n_ph;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    bit ack_e;
    ack_e = m_enab && m_aak && (rx_kind == 1 || rx_kind == 3 || (rx_kind == 2 && gc_enable));
    chk("R2", "ctl", ctl_rdata, {m_ien, m_enab, m_sta, m_stp, m_iflg, m_aak, 2'b00});
    chk("R4", "state", state_code, m_state);
    chk("R3", "irq", irq, m_ien && m_iflg);
    chk("R6", "scl_hold", scl_hold, m_enab && m_iflg);
    chk("R7", "stop_req", stop_req, m_ph == 1);
    chk("R9", "start_req", start_req, m_ph == 2);
    chk("R11", "ack", ack_drive, ack_e);
    chk("R12", "last", last_byte, m_enab && slave_tx && !m_aak);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (rst_n) compare_all();
    if (stop_req && first_stop < 0) first_stop = cyc;
    if (start_req && first_start < 0) first_start = cyc;
    if (start_req || stop_req) begin
      reqcnt++;
      eng_done = (reqcnt == 3);
      if (eng_done) reqcnt = 0;
    end else begin
      reqcnt = 0; eng_done = 0;
    end
    cpu_wr = 0; ev_valid = 0;
  endtask

  task automatic wr(logic [7:0] v);
    cpu_wr = 1; cpu_wdata = v[7:2];
    step();
  endtask

  task automatic ev(logic [7:0] c);
    ev_valid = 1; ev_code = c;
    step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset ctl", ctl_rdata, 0);
    chk("R1", "reset state", state_code, 8'hF8);
    chk("R1", "reset outs", {irq, scl_hold, start_req, stop_req, ack_drive, last_byte}, 0);

    wr(8'hC4);
    ev(8'h60);
    chk("R6", "stretch on flag", scl_hold, 1);
    chk("R3", "irq on flag", irq, 1);
    wr(8'hCC);
    chk("R6", "write 1 keeps flag", ctl_rdata[3], 1);
    wr(8'hC4);
    chk("R6", "write 0 releases", scl_hold, 0);
    ev(8'hF8);
    chk("R4", "idle code no flag", ctl_rdata[3], 0);

    for (int a = 0; a < 2; a++)
      for (int g = 0; g < 2; g++)
        for (int k = 0; k < 4; k++) begin
          gc_enable = g[0]; rx_kind = k[1:0]; slave_tx = k[0];
          if (k == 0) wr(a ? 8'h44 : 8'h40); else step();
          chk("R11", "ack case", ack_drive, a == 1 && (k == 1 || k == 3 || (k == 2 && g == 1)));
          chk("R12", "last byte", last_byte, a == 0 && k[0]);
        end
    rx_kind = 0; slave_tx = 0;

    is_master = 1;
    wr(8'hD4);
    step();
    chk("R7", "stop raised", stop_req, 1);
    wr(8'hC4);
    chk("R10", "stp kept after write 0", ctl_rdata[4], 1);
    repeat (4) step();
    chk("R7", "stp cleared", ctl_rdata[4], 0);
    chk("R7", "state idle", state_code, 8'hF8);

    first_stop = -1; first_start = -1;
    wr(8'hF4);
    repeat (12) step();
    chk("R9", "stop seen", first_stop > 0, 1);
    chk("R9", "start after stop", first_start > first_stop + 2, 1);
    chk("R9", "sta cleared", ctl_rdata[5], 0);

    is_master = 0;
    ev(8'h80);
    wr(8'hDC);
    repeat (3) step();
    chk("R13", "stop waits on flag", {ctl_rdata[4], stop_req}, 2'b10);
    wr(8'hD4);
    step();
    chk("R8", "slave stop no req", stop_req, 0);
    chk("R8", "slave stp cleared", ctl_rdata[4], 0);
    chk("R8", "slave state idle", state_code, 8'hF8);

    wr(8'h04);
    ev(8'h80);
    chk("R5", "event ignored", {state_code, ctl_rdata[3]}, {8'hF8, 1'b0});
    wr(8'h24);
    repeat (3) step();
    chk("R5", "no start when off", {start_req, scl_hold}, 0);
    wr(8'h04);
    step();
    finish_run();
  end
endmodule